// File: doc/BRIEF.md
# Bank-Sequenced Dual-Readout ADC Controller

This block sequences a bank-organised analog-to-digital converter. One start command makes it sample every channel of the selected bank (seven channels, indices 0 to 6) in ascending order through a request/acknowledge sample port. Each 10-bit result goes into a seven-entry result store. When the last channel has been captured, the busy flag drops and a single-cycle done pulse is raised.

Two 3-bit selector fields in the control register act as output multiplexers over the store. The result register always shows the stored values of the two selected channels side by side. Software can therefore read back any pair of results after one conversion by rewriting the selectors, without converting again. Clearing the enable bit puts the block in its idle state: a conversion in progress is abandoned and start commands are ignored. The converter itself is outside the block and is represented by the sample port.

Register access uses a write strobe, a register select (0 for control, 1 for result) and a 32-bit write word. Both registers are visible at all times on their own read ports.

Top module: `adc_bank_sequencer`

## Requirements
- R1: After reset, the control readback, the result readback, the sample request and the done pulse are all 0, and every stored result is 0.
- R2: The control register keeps enable in bit 0, bank select in bit 2 (1 = bank 1), selector A in bits 6:4 and selector B in bits 9:7. These bits read back as written and all other control bits read as 0.
- R3: A write to the result register with bit 22 set, while enable is 1 and no conversion is running, sets result bit 22 (busy) from the next cycle and raises the sample request.
- R4: A conversion requests channels 0 to 6 in ascending order. Each request holds its channel index and the bank value captured at start until it is acknowledged.
- R5: Result bits 9:0 show the stored value of the channel named by selector A, and bits 19:10 show the one named by selector B. A selector value of 7 shows 0. Bits 20, 21 and 23 to 31 read as 0.
- R6: Changing the selectors updates the result readback in the next cycle and does not start any sampling.
- R7: In the cycle after the seventh acknowledge, busy reads 0 and the done output is high for exactly that one cycle.
- R8: A start write while enable is 0 has no effect: busy stays 0, no sample is requested and the readback is unchanged.
- R9: A start write during a running conversion is ignored: the run still takes exactly seven samples and yields one done pulse.
- R10: Writing 0 to the enable bit during a conversion stops it in the next cycle with no done pulse. Results captured before the stop are kept.
- R11: A result-register write with bit 22 clear starts nothing and changes no readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 result |
| regWrData | input | 32 | Register write data |
| ctrlRd | output | 32 | Control register readback |
| resultRd | output | 32 | Result register readback (two results, busy bit 22) |
| smpReq | output | 1 | Sample request to the converter |
| smpBank | output | 1 | Bank of the requested sample |
| smpChan | output | 3 | Channel of the requested sample |
| smpAck | input | 1 | Converter acknowledge; data valid with it |
| smpData | input | 10 | Converted sample value |
| doneIrq | output | 1 | One-cycle end-of-conversion event |

## Verification
The properties assume that the converter asserts the acknowledge only while a request is pending, holds it for one cycle at a time, and drives valid data in that same cycle. The bench responder acknowledges only an observed request, after a random delay, and deasserts the acknowledge in every cycle in which it does not answer. Before any abort is issued, the stimulus stops the responder so that no acknowledge coincides with a disable write. This keeps the expected store contents unambiguous.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W     = 32;
  localparam int EN_BIT    = 0;
  localparam int BANK_BIT  = 2;
  localparam int SELA_LSB  = 4;
  localparam int SELB_LSB  = 7;
  localparam int START_BIT = 22;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_SAMPLE = 1'b1
  } seqState_e;

  // Strobes from control to datapath; chan width fixed at the widest default.
  typedef struct packed {
    logic       capture;
    logic [2:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            abortReq,
  input  logic            enable,
  input  logic            bankSel,
  input  logic            smpAck,
  output logic            busy,
  output logic            smpReq,
  output logic            smpBank,
  output logic [CH_W-1:0] smpChan,
  output logic            doneIrq,
  output seqStrobe_t      strobe
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seqState_e        stateQ;
  logic [CH_W-1:0]  chanQ;
  logic             bankQ;
  logic             doneQ;
  logic             startGo;

  assign startGo = startReq && enable && (stateQ == SEQ_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      chanQ  <= '0;
      bankQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        SEQ_IDLE: begin
          if (startGo) begin
            stateQ <= SEQ_SAMPLE;
            chanQ  <= '0;
            bankQ  <= bankSel;
          end
        end
        SEQ_SAMPLE: begin
          if (abortReq) begin
            stateQ <= SEQ_IDLE;
          end else if (smpAck) begin
            if (chanQ == LAST_CH) begin
              stateQ <= SEQ_IDLE;
              doneQ  <= 1'b1;
            end else begin
              chanQ <= chanQ + 1'b1;
            end
          end
        end
        default: stateQ <= SEQ_IDLE;
      endcase
    end
  end

  assign busy    = (stateQ == SEQ_SAMPLE);
  assign smpReq  = busy;
  assign smpBank = bankQ;
  assign smpChan = chanQ;
  assign doneIrq = doneQ;

  always_comb begin
    strobe         = '0;
    strobe.capture = busy && smpAck && !abortReq;
    strobe.chan    = 3'(chanQ);
  end
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int RES_W  = 10,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrite,
  input  logic             wrEnable,
  input  logic             wrBank,
  input  logic [CH_W-1:0]  wrSelA,
  input  logic [CH_W-1:0]  wrSelB,
  input  seqStrobe_t       strobe,
  input  logic [RES_W-1:0] smpData,
  input  logic             busy,
  output logic             enable,
  output logic             bankSel,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] resultRd
);
  logic                         enQ;
  logic                         bankQ;
  logic [CH_W-1:0]              selAQ;
  logic [CH_W-1:0]              selBQ;
  logic [NUM_CH-1:0][RES_W-1:0] storeQ;
  logic [RES_W-1:0]             outA;
  logic [RES_W-1:0]             outB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      bankQ <= 1'b0;
      selAQ <= '0;
      selBQ <= '0;
    end else if (ctrlWrite) begin
      enQ   <= wrEnable;
      bankQ <= wrBank;
      selAQ <= wrSelA;
      selBQ <= wrSelB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobe.capture && (strobe.chan == 3'(i)))
          storeQ[i] <= smpData;
      end
    end
  end

  // Output multiplexers; an index past the last channel reads as zero.
  always_comb begin
    outA = '0;
    outB = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (selAQ == CH_W'(i)) outA = storeQ[i];
      if (selBQ == CH_W'(i)) outB = storeQ[i];
    end
  end

  always_comb begin
    ctrlRd                      = '0;
    ctrlRd[EN_BIT]              = enQ;
    ctrlRd[BANK_BIT]            = bankQ;
    ctrlRd[SELA_LSB +: CH_W]    = selAQ;
    ctrlRd[SELB_LSB +: CH_W]    = selBQ;
  end

  always_comb begin
    resultRd                    = '0;
    resultRd[0 +: RES_W]        = outA;
    resultRd[RES_W +: RES_W]    = outB;
    resultRd[START_BIT]         = busy;
  end

  assign enable  = enQ;
  assign bankSel = bankQ;
endmodule

// File: rtl/adc_bank_sequencer.sv
module adc_bank_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int RES_W  = 10,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] resultRd,
  output logic             smpReq,
  output logic             smpBank,
  output logic [CH_W-1:0]  smpChan,
  input  logic             smpAck,
  input  logic [RES_W-1:0] smpData,
  output logic             doneIrq
);
  logic       ctrlWrite;
  logic       startReq;
  logic       abortReq;
  logic       enable;
  logic       bankSel;
  logic       busy;
  seqStrobe_t strobe;
  logic       unusedWrBits;

  assign ctrlWrite = regWrEn && !regSel;
  assign startReq  = regWrEn && regSel && regWrData[START_BIT];
  assign abortReq  = ctrlWrite && !regWrData[EN_BIT];
  assign unusedWrBits = ^{regWrData[REG_W-1:START_BIT+1], regWrData[START_BIT-1:SELB_LSB+CH_W],
                          regWrData[BANK_BIT+1], regWrData[EN_BIT+1]};

  adc_seq_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .abortReq (abortReq),
    .enable   (enable),
    .bankSel  (bankSel),
    .smpAck   (smpAck),
    .busy     (busy),
    .smpReq   (smpReq),
    .smpBank  (smpBank),
    .smpChan  (smpChan),
    .doneIrq  (doneIrq),
    .strobe   (strobe)
  );

  adc_seq_dpath #(.NUM_CH(NUM_CH), .RES_W(RES_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrite (ctrlWrite),
    .wrEnable  (regWrData[EN_BIT]),
    .wrBank    (regWrData[BANK_BIT]),
    .wrSelA    (regWrData[SELA_LSB +: CH_W]),
    .wrSelB    (regWrData[SELB_LSB +: CH_W]),
    .strobe    (strobe),
    .smpData   (smpData),
    .busy      (busy),
    .enable    (enable),
    .bankSel   (bankSel),
    .ctrlRd    (ctrlRd),
    .resultRd  (resultRd)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regSel,
  input logic [31:0] regWrData,
  input logic [31:0] ctrlRd,
  input logic [31:0] resultRd,
  input logic        smpReq,
  input logic        smpBank,
  input logic [2:0]  smpChan,
  input logic        smpAck,
  input logic        doneIrq
);
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && regWrData[22] && ctrlRd[0] && !resultRd[22]) |=> (resultRd[22] && smpReq));

  a_r4_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && !smpAck && !(regWrEn && !regSel && !regWrData[0]))
      |=> (smpReq && $stable(smpChan) && $stable(smpBank)));

  a_r4_chan_in_range: assert property (@(posedge clk) disable iff (!rstN)
    smpReq |-> (smpChan < 3'd7));

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!resultRd[22] && $past(resultRd[22])));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  a_r8_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[0] |-> (!smpReq && !resultRd[22]));

  a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && regWrEn && !regSel && !regWrData[0]) |=> (!smpReq && !doneIrq));

  a_r5_unused_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resultRd[31:23] == 9'd0) && (resultRd[21:20] == 2'd0));
endmodule

bind adc_bank_sequencer adc_seq_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .ctrlRd    (ctrlRd),
  .resultRd  (resultRd),
  .smpReq    (smpReq),
  .smpBank   (smpBank),
  .smpChan   (smpChan),
  .smpAck    (smpAck),
  .doneIrq   (doneIrq)
);

// File: tb/tb_adc_bank_sequencer.sv
`timescale 1ns/1ps
module tb_adc_bank_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] ctrlRd;
  logic [31:0] resultRd;
  logic        smpReq;
  logic        smpBank;
  logic [2:0]  smpChan;
  logic        smpAck = 1'b0;
  logic [9:0]  smpData = '0;
  logic        doneIrq;

  int   checkCount = 0;
  int   failCount  = 0;
  bit   respOn = 1'b1;
  int   acksThisRun = 0;
  int   nextExpChan = 0;
  bit   expBank = 1'b0;
  int   doneCount = 0;
  logic [9:0] expBuf [7];
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  adc_bank_sequencer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .ctrlRd(ctrlRd), .resultRd(resultRd), .smpReq(smpReq), .smpBank(smpBank),
    .smpChan(smpChan), .smpAck(smpAck), .smpData(smpData), .doneIrq(doneIrq)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  function automatic logic [31:0] ctrlWord(bit en, bit bank, int sa, int sb);
    return 32'(en) | (32'(bank) << 2) | ((32'(sa) & 7) << 4) | ((32'(sb) & 7) << 7);
  endfunction

  function automatic logic [31:0] expResult(int sa, int sb, bit busy);
    logic [9:0] a = (sa < 7) ? expBuf[sa] : 10'd0;
    logic [9:0] b = (sb < 7) ? expBuf[sb] : 10'd0;
    return {9'd0, busy, 2'd0, b, a};
  endfunction

  task automatic wrReg(bit sel, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // Converter model: answers an observed request after a random delay.
  initial begin
    forever begin
      @(negedge clk);
      if (respOn && smpReq && ($urandom % 3 != 0)) begin
        chk("R4", "channel order", smpChan, nextExpChan);
        chk("R4", "bank", smpBank, expBank);
        smpData = 10'($urandom);
        expBuf[smpChan] = smpData;
        nextExpChan++;
        acksThisRun++;
        smpAck = 1'b1;
      end else begin
        smpAck = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (doneIrq) doneCount++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    endRun();
  end

  // Start a run and wait for the done pulse; checks R3 and R7 along the way.
  task automatic runConv(bit bank, int sa, int sb);
    int n = 0;
    wrReg(0, ctrlWord(1, bank, sa, sb));
    expBank = bank; nextExpChan = 0; acksThisRun = 0;
    wrReg(1, 32'h0040_0000);
    chk("R3", "busy after start", resultRd[22], 1);
    chk("R3", "request after start", smpReq, 1);
    while (!doneIrq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R7", "done seen", doneIrq, 1);
    chk("R7", "busy cleared with done", resultRd[22], 0);
    chk("R7", "seven samples", acksThisRun, 7);
    chk("R5", "result readback", resultRd, expResult(sa, sb, 0));
    @(negedge clk);
    chk("R7", "done one cycle", doneIrq, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 7; i++) expBuf[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ctrl reset", ctrlRd, 0);
    chk("R1", "result reset", resultRd, 0);
    chk("R1", "req reset", smpReq, 0);
    chk("R1", "done reset", doneIrq, 0);

    wrReg(0, 32'hFFFF_FFFF);
    chk("R2", "ctrl all-ones", ctrlRd, 32'h0000_03F5);
    wrReg(0, ctrlWord(0, 1, 5, 2));
    chk("R2", "ctrl fields", ctrlRd, 32'h0000_0154);

    // R8: start while disabled
    wrReg(1, 32'h0040_0000);
    for (int i = 0; i < 4; i++) begin
      chk("R8", "no busy", resultRd, 0);
      chk("R8", "no request", smpReq, 0);
      @(negedge clk);
    end

    // R11: result write without the start bit
    wrReg(0, ctrlWord(1, 0, 0, 1));
    wrReg(1, 32'hFFBF_FFFF);
    for (int i = 0; i < 4; i++) begin
      chk("R11", "no start", smpReq, 0);
      chk("R11", "readback unchanged", resultRd, 0);
      @(negedge clk);
    end

    runConv(0, 0, 6);
    runConv(1, 7, 3);

    for (int r = 0; r < 15; r++) begin
      bit bank = 1'($urandom);
      runConv(bank, int'($urandom % 8), int'($urandom % 8));
      for (int k = 0; k < 3; k++) begin
        int sa = int'($urandom % 8);
        int sb = int'($urandom % 8);
        wrReg(0, ctrlWord(1, bank, sa, sb));
        chk("R6", "reselect readback", resultRd, expResult(sa, sb, 0));
        chk("R6", "no sampling on reselect", smpReq, 0);
      end
    end

    // R9: restart during a run is ignored
    begin
      int d0;
      int n = 0;
      wrReg(0, ctrlWord(1, 0, 1, 4));
      expBank = 0; nextExpChan = 0; acksThisRun = 0;
      d0 = doneCount;
      wrReg(1, 32'h0040_0000);
      while (acksThisRun < 3) @(negedge clk);
      wrReg(1, 32'h0040_0000);
      while (!doneIrq && n < 2000) begin @(negedge clk); n++; end
      repeat (20) @(negedge clk);
      chk("R9", "samples in run", acksThisRun, 7);
      chk("R9", "done pulses", doneCount - d0, 1);
      chk("R9", "idle after run", smpReq, 0);
      chk("R9", "readback", resultRd, expResult(1, 4, 0));
    end

    // R10: disable during a run
    begin
      int d0;
      wrReg(0, ctrlWord(1, 1, 0, 0));
      expBank = 1; nextExpChan = 0; acksThisRun = 0;
      d0 = doneCount;
      wrReg(1, 32'h0040_0000);
      while (acksThisRun < 4) @(negedge clk);
      respOn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "still busy before abort", resultRd[22], 1);
      wrReg(0, ctrlWord(0, 1, 0, 1));
      chk("R10", "busy cleared", resultRd[22], 0);
      chk("R10", "request dropped", smpReq, 0);
      repeat (6) @(negedge clk);
      chk("R10", "no done pulse", doneCount - d0, 0);
      for (int c = 0; c < 7; c += 2) begin
        wrReg(0, ctrlWord(0, 1, c, (c + 1) % 8));
        chk("R10", "stored results kept", resultRd, expResult(c, (c + 1) % 8, 0));
      end
      respOn = 1'b1;
      runConv(0, 2, 5);
    end

    endRun();
  end
endmodule